// File: doc/BRIEF.md
# CAN Receive Mailbox Update Engine

This block keeps a small bank of CAN receive mailboxes and writes accepted frames into them. A receive front end delivers frames that have already passed filtering, each one tagged with the index of its target mailbox, over a valid/ready stream. For every frame the block runs a fixed four-step write. It first captures the current value of a free-running 16-bit timer as the timestamp. It then stores the received identifier, the 8 data bytes and the 4-bit length. Next it updates the code field, and last it raises the mailbox's interrupt flag. While the write is in progress, a BUSY bit shows in the code the CPU reads.

The CPU side works through plain strobes. To arm a mailbox, the CPU writes its identifier and the code 0100. A control-word read locks the mailbox it addresses, and a read of the timer removes that lock. A frame that targets a locked mailbox waits in a one-frame holding slot and is written once the lock is gone. A further frame for a locked mailbox that arrives while the slot is occupied is discarded and reported.

Stream rules: a transfer takes place on a rising edge where `frm_valid` and `frm_ready` are both high. `frm_ready` depends only on internal state and on the CPU strobes of that cycle, never on `frm_valid`. It is low for the four update cycles, and also in any idle cycle in which the holding slot is being drained. While `frm_valid` is high and `frm_ready` is low, the source holds the payload stable.

Top module: `rxmb_update`

## Requirements
- R1: A frame is stored only when its target mailbox has a receiving code: EMPTY 0100, FULL 0010 or OVERRUN 0110. Writing ID and then code 0100 arms a mailbox. Under any other code, such as 0000 (inactive), a frame is accepted and dropped, and the mailbox's ID, code and flag do not change.
- R2: After a frame is accepted at edge E0, the timestamp is written at E0+1, ID/data/length at E0+2, the code at E0+3 and the flag at E0+4. `frm_ready` is high when idle and low during these four cycles.
- R3: `cpu_timer` is 0 at reset and rises by 1 each clock, wrapping at 16 bits. The stored timestamp equals the timer value held between E0 and E0+1.
- R4: All 64 data bits are stored. The 4-bit length is stored as received, including values above 8.
- R5: The written code is FULL (0010) if the mailbox was read or armed since its previous frame, and OVERRUN (0110) otherwise.
- R6: A mailbox's bit in `flags` is set by its frame write whatever the mask. `irq` is high when any bit of `flags & irq_mask` is high. A 1 on `flag_clr` clears that flag. A set in the same cycle wins over the clear.
- R7: Bit 0 of `cpu_code` (BUSY) reads 1 for a mailbox during its timestamp, body and code cycles, and 0 otherwise.
- R8: A `cpu_rd_ctrl` strobe on a mailbox that is not busy locks that mailbox and moves any existing lock to it. Only one mailbox is locked at a time. A `cpu_rd_timer` strobe releases the lock. A frame never starts on the locked mailbox.
- R9: A frame for a locked mailbox is accepted into a holding slot if the slot is empty. In the first idle cycle after its mailbox stops being locked, that frame starts its update, and `frm_ready` is low in that cycle.
- R10: A frame for a locked mailbox while the slot is full is dropped. `rx_lost` is high in its acceptance cycle, and the held frame is the one later written.
- R11: CPU ID or code writes to a busy mailbox have no effect.
- R12: Reset clears all codes, flags and locks, and sets `irq` low and `frm_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | Incoming frame valid |
| frm_ready | output | 1 | Block can take a frame |
| frm_mb | input | IDX_W | Target mailbox of the frame |
| frm_id | input | ID_W | Received identifier |
| frm_data | input | DATA_W | Received data bytes |
| frm_len | input | 4 | Received length code |
| rx_lost | output | 1 | Frame dropped because holding slot full |
| cpu_mb | input | IDX_W | Mailbox addressed by the CPU |
| cpu_rd_ctrl | input | 1 | Control-word read strobe (locks) |
| cpu_rd_timer | input | 1 | Timer read strobe (unlocks) |
| cpu_wr_id | input | 1 | ID write strobe |
| cpu_wr_code | input | 1 | Code write strobe |
| cpu_wdata_id | input | ID_W | ID write value |
| cpu_wdata_code | input | 4 | Code write value |
| cpu_code | output | 4 | Code of addressed mailbox, bit 0 = BUSY |
| cpu_len | output | 4 | Length of addressed mailbox |
| cpu_ts | output | TS_W | Timestamp of addressed mailbox |
| cpu_id | output | ID_W | ID of addressed mailbox |
| cpu_data | output | DATA_W | Data of addressed mailbox |
| cpu_timer | output | TS_W | Free-running timer |
| flag_clr | input | NUM_MB | Write-one-to-clear for flags |
| irq_mask | input | NUM_MB | Interrupt enables |
| flags | output | NUM_MB | Interrupt flags |
| irq | output | 1 | Masked interrupt request |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. They check that the four update steps follow one another and that ready stays low while the sequencer runs. They also check that the flag rises right after the code step and that BUSY is visible at the start of an update. No update may start on the mailbox that was locked in the cycle of its start, a dropped frame implies an occupied slot, the timer steps by one, and a zero mask keeps `irq` low. Other behaviours only show up in the bench scenarios. These cover the actual field values and their staggered appearance, FULL versus OVERRUN after servicing, and the irq result over every mask and flag pattern. They also cover the lock moving between mailboxes, the frame held back and later released, and ignored writes during BUSY.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam logic [3:0] CODE_INACTIVE = 4'b0000;
  localparam logic [3:0] CODE_EMPTY    = 4'b0100;
  localparam logic [3:0] CODE_FULL     = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TS,
    ST_BODY,
    ST_CODE,
    ST_FLAG
  } upd_state_e;

  function automatic logic code_receives(input logic [3:0] c);
    return (c == CODE_EMPTY) || (c == CODE_FULL) || (c == CODE_OVERRUN);
  endfunction
endpackage

// File: rtl/rxmb_timer.sv
module rxmb_timer #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/rxmb_lock.sv
module rxmb_lock #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq,
  input  logic [IDX_W-1:0] acq_idx,
  input  logic             rel,
  output logic             lock_valid,
  output logic [IDX_W-1:0] lock_idx
);
  // acquisition wins over release in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_valid <= 1'b0;
      lock_idx   <= '0;
    end else if (acq) begin
      lock_valid <= 1'b1;
      lock_idx   <= acq_idx;
    end else if (rel) begin
      lock_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store #(
  parameter int NUM_MB = 4,
  parameter int IDX_W  = 2,
  parameter int ID_W   = 29,
  parameter int TS_W   = 16,
  parameter int DATA_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              eng_idx,
  input  logic                          eng_ts_we,
  input  logic [TS_W-1:0]               eng_ts,
  input  logic                          eng_body_we,
  input  logic [ID_W-1:0]               eng_id,
  input  logic [DATA_W-1:0]             eng_data,
  input  logic [3:0]                    eng_len,
  input  logic                          eng_code_we,
  input  logic [3:0]                    eng_code,
  input  logic                          eng_flag_set,
  input  logic [IDX_W-1:0]              cpu_idx,
  input  logic                          cpu_id_we,
  input  logic [ID_W-1:0]               cpu_id,
  input  logic                          cpu_code_we,
  input  logic [3:0]                    cpu_code,
  input  logic                          cpu_seen,
  input  logic [NUM_MB-1:0]             flag_clr,
  output logic [NUM_MB-1:0][3:0]        mb_code,
  output logic [NUM_MB-1:0][ID_W-1:0]   mb_id,
  output logic [NUM_MB-1:0][DATA_W-1:0] mb_data,
  output logic [NUM_MB-1:0][3:0]        mb_len,
  output logic [NUM_MB-1:0][TS_W-1:0]   mb_ts,
  output logic [NUM_MB-1:0]             mb_unread,
  output logic [NUM_MB-1:0]             flags
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    logic eng_hit, cpu_hit;
    assign eng_hit = (eng_idx == IDX_W'(i));
    assign cpu_hit = (cpu_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mb_code[i]   <= rxmb_pkg::CODE_INACTIVE;
        mb_id[i]     <= '0;
        mb_data[i]   <= '0;
        mb_len[i]    <= '0;
        mb_ts[i]     <= '0;
        mb_unread[i] <= 1'b0;
        flags[i]     <= 1'b0;
      end else begin
        if (eng_hit && eng_ts_we) mb_ts[i] <= eng_ts;
        if (eng_hit && eng_body_we) begin
          mb_id[i]   <= eng_id;
          mb_data[i] <= eng_data;
          mb_len[i]  <= eng_len;
        end else if (cpu_hit && cpu_id_we) begin
          mb_id[i] <= cpu_id;
        end
        if (eng_hit && eng_code_we) begin
          mb_code[i]   <= eng_code;
          mb_unread[i] <= 1'b1;
        end else if (cpu_hit && cpu_code_we) begin
          mb_code[i]   <= cpu_code;
          mb_unread[i] <= 1'b0;
        end else if (cpu_hit && cpu_seen) begin
          mb_unread[i] <= 1'b0;
        end
        if (eng_hit && eng_flag_set) flags[i] <= 1'b1;
        else if (flag_clr[i])        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxmb_update.sv
module rxmb_update #(
  parameter int NUM_MB    = 4,
  parameter int ID_W      = 29,
  parameter int TS_W      = 16,
  parameter int MAX_BYTES = 8,
  localparam int IDX_W    = $clog2(NUM_MB),
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [IDX_W-1:0]  frm_mb,
  input  logic [ID_W-1:0]   frm_id,
  input  logic [DATA_W-1:0] frm_data,
  input  logic [3:0]        frm_len,
  output logic              rx_lost,
  input  logic [IDX_W-1:0]  cpu_mb,
  input  logic              cpu_rd_ctrl,
  input  logic              cpu_rd_timer,
  input  logic              cpu_wr_id,
  input  logic              cpu_wr_code,
  input  logic [ID_W-1:0]   cpu_wdata_id,
  input  logic [3:0]        cpu_wdata_code,
  output logic [3:0]        cpu_code,
  output logic [3:0]        cpu_len,
  output logic [TS_W-1:0]   cpu_ts,
  output logic [ID_W-1:0]   cpu_id,
  output logic [DATA_W-1:0] cpu_data,
  output logic [TS_W-1:0]   cpu_timer,
  input  logic [NUM_MB-1:0] flag_clr,
  input  logic [NUM_MB-1:0] irq_mask,
  output logic [NUM_MB-1:0] flags,
  output logic              irq
);
  import rxmb_pkg::*;

  upd_state_e        st;
  logic [IDX_W-1:0]  work_mb;
  logic [ID_W-1:0]   work_id;
  logic [DATA_W-1:0] work_data;
  logic [3:0]        work_len;

  logic              pend_valid;
  logic [IDX_W-1:0]  pend_mb;
  logic [ID_W-1:0]   pend_id;
  logic [DATA_W-1:0] pend_data;
  logic [3:0]        pend_len;

  logic              lock_valid;
  logic [IDX_W-1:0]  lock_idx;

  logic [NUM_MB-1:0][3:0]        mb_code;
  logic [NUM_MB-1:0][ID_W-1:0]   mb_id;
  logic [NUM_MB-1:0][DATA_W-1:0] mb_data;
  logic [NUM_MB-1:0][3:0]        mb_len;
  logic [NUM_MB-1:0][TS_W-1:0]   mb_ts;
  logic [NUM_MB-1:0]             mb_unread;

  logic [NUM_MB-1:0] busy_vec;
  logic [NUM_MB-1:0] locked_vec;
  logic              updating;
  logic              cpu_busy;
  logic              acq;
  logic              pend_go, pend_start;
  logic              take, in_rx, in_locked, in_go, in_park;

  rxmb_timer #(.TS_W(TS_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cpu_timer)
  );

  assign updating = (st == ST_TS) || (st == ST_BODY) || (st == ST_CODE);
  assign cpu_busy = busy_vec[cpu_mb];
  assign acq      = cpu_rd_ctrl && !cpu_busy;

  // a mailbox counts as locked for this cycle if held or being locked now
  for (genvar i = 0; i < NUM_MB; i++) begin : g_state
    assign busy_vec[i]   = updating && (work_mb == IDX_W'(i));
    assign locked_vec[i] = (lock_valid && (lock_idx == IDX_W'(i))) ||
                           (acq && (cpu_mb == IDX_W'(i)));
  end

  rxmb_lock #(.IDX_W(IDX_W)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq        (acq),
    .acq_idx    (cpu_mb),
    .rel        (cpu_rd_timer),
    .lock_valid (lock_valid),
    .lock_idx   (lock_idx)
  );

  // held frame drains first; a held frame whose mailbox stopped receiving is dropped
  assign pend_go    = (st == ST_IDLE) && pend_valid && !locked_vec[pend_mb];
  assign pend_start = pend_go && code_receives(mb_code[pend_mb]);
  assign frm_ready  = (st == ST_IDLE) && !pend_go;
  assign take       = frm_valid && frm_ready;
  assign in_rx      = take && code_receives(mb_code[frm_mb]);
  assign in_locked  = locked_vec[frm_mb];
  assign in_go      = in_rx && !in_locked;
  assign in_park    = in_rx && in_locked && !pend_valid;
  assign rx_lost    = in_rx && in_locked && pend_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      work_mb    <= '0;
      work_id    <= '0;
      work_data  <= '0;
      work_len   <= '0;
      pend_valid <= 1'b0;
      pend_mb    <= '0;
      pend_id    <= '0;
      pend_data  <= '0;
      pend_len   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (pend_start) begin
            work_mb   <= pend_mb;
            work_id   <= pend_id;
            work_data <= pend_data;
            work_len  <= pend_len;
            st        <= ST_TS;
          end else if (in_go) begin
            work_mb   <= frm_mb;
            work_id   <= frm_id;
            work_data <= frm_data;
            work_len  <= frm_len;
            st        <= ST_TS;
          end
        end
        ST_TS:   st <= ST_BODY;
        ST_BODY: st <= ST_CODE;
        ST_CODE: st <= ST_FLAG;
        default: st <= ST_IDLE;
      endcase
      if (pend_go) begin
        pend_valid <= 1'b0;
      end else if (in_park) begin
        pend_valid <= 1'b1;
        pend_mb    <= frm_mb;
        pend_id    <= frm_id;
        pend_data  <= frm_data;
        pend_len   <= frm_len;
      end
    end
  end

  rxmb_store #(
    .NUM_MB (NUM_MB),
    .IDX_W  (IDX_W),
    .ID_W   (ID_W),
    .TS_W   (TS_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .eng_idx      (work_mb),
    .eng_ts_we    (st == ST_TS),
    .eng_ts       (cpu_timer),
    .eng_body_we  (st == ST_BODY),
    .eng_id       (work_id),
    .eng_data     (work_data),
    .eng_len      (work_len),
    .eng_code_we  (st == ST_CODE),
    .eng_code     (mb_unread[work_mb] ? CODE_OVERRUN : CODE_FULL),
    .eng_flag_set (st == ST_FLAG),
    .cpu_idx      (cpu_mb),
    .cpu_id_we    (cpu_wr_id && !cpu_busy),
    .cpu_id       (cpu_wdata_id),
    .cpu_code_we  (cpu_wr_code && !cpu_busy),
    .cpu_code     (cpu_wdata_code),
    .cpu_seen     (acq),
    .flag_clr     (flag_clr),
    .mb_code      (mb_code),
    .mb_id        (mb_id),
    .mb_data      (mb_data),
    .mb_len       (mb_len),
    .mb_ts        (mb_ts),
    .mb_unread    (mb_unread),
    .flags        (flags)
  );

  assign cpu_code = mb_code[cpu_mb] | {3'b000, cpu_busy};
  assign cpu_len  = mb_len[cpu_mb];
  assign cpu_ts   = mb_ts[cpu_mb];
  assign cpu_id   = mb_id[cpu_mb];
  assign cpu_data = mb_data[cpu_mb];
  assign irq      = |(flags & irq_mask);
endmodule

// File: rtl/rxmb_update_chk.sv
module rxmb_update_chk #(
  parameter int NUM_MB = 4,
  parameter int IDX_W  = 2,
  parameter int TS_W   = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input rxmb_pkg::upd_state_e   st,
  input logic [IDX_W-1:0]       work_mb,
  input logic                   lock_valid,
  input logic [IDX_W-1:0]       lock_idx,
  input logic                   pend_valid,
  input logic                   frm_ready,
  input logic                   rx_lost,
  input logic [IDX_W-1:0]       cpu_mb,
  input logic [3:0]             cpu_code,
  input logic [TS_W-1:0]        cpu_timer,
  input logic [NUM_MB-1:0]      flags,
  input logic [NUM_MB-1:0]      irq_mask,
  input logic                   irq
);
  import rxmb_pkg::*;

  assert_ready_low_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !frm_ready);

  assert_body_after_ts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY) |-> ($past(st) == ST_TS));

  assert_code_after_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CODE) |-> ($past(st) == ST_BODY));

  assert_timer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cpu_timer == $past(cpu_timer) + {{(TS_W-1){1'b0}}, 1'b1}));

  assert_flag_after_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLAG) |=> flags[$past(work_mb)]);

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

  assert_busy_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_TS) && (cpu_mb == work_mb)) |-> cpu_code[0]);

  assert_no_start_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TS) |-> !($past(lock_valid) && ($past(lock_idx) == work_mb)));

  assert_lost_needs_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lost |-> pend_valid);
endmodule

bind rxmb_update rxmb_update_chk #(
  .NUM_MB (NUM_MB),
  .IDX_W  (IDX_W),
  .TS_W   (TS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st         (st),
  .work_mb    (work_mb),
  .lock_valid (lock_valid),
  .lock_idx   (lock_idx),
  .pend_valid (pend_valid),
  .frm_ready  (frm_ready),
  .rx_lost    (rx_lost),
  .cpu_mb     (cpu_mb),
  .cpu_code   (cpu_code),
  .cpu_timer  (cpu_timer),
  .flags      (flags),
  .irq_mask   (irq_mask),
  .irq        (irq)
);

// File: tb/rxmb_update_bench.sv
module rxmb_update_bench;
  localparam int NMB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [1:0]  frm_mb = '0;
  logic [28:0] frm_id = '0;
  logic [63:0] frm_data = '0;
  logic [3:0]  frm_len = '0;
  logic        rx_lost;
  logic [1:0]  cpu_mb = '0;
  logic        cpu_rd_ctrl = 1'b0;
  logic        cpu_rd_timer = 1'b0;
  logic        cpu_wr_id = 1'b0;
  logic        cpu_wr_code = 1'b0;
  logic [28:0] cpu_wdata_id = '0;
  logic [3:0]  cpu_wdata_code = '0;
  logic [3:0]  cpu_code;
  logic [3:0]  cpu_len;
  logic [15:0] cpu_ts;
  logic [28:0] cpu_id;
  logic [63:0] cpu_data;
  logic [15:0] cpu_timer;
  logic [3:0]  flag_clr = '0;
  logic [3:0]  irq_mask = '0;
  logic [3:0]  flags;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rxmb_update u_rxmb_update (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_mb(frm_mb),
    .frm_id(frm_id), .frm_data(frm_data), .frm_len(frm_len), .rx_lost(rx_lost),
    .cpu_mb(cpu_mb), .cpu_rd_ctrl(cpu_rd_ctrl), .cpu_rd_timer(cpu_rd_timer),
    .cpu_wr_id(cpu_wr_id), .cpu_wr_code(cpu_wr_code),
    .cpu_wdata_id(cpu_wdata_id), .cpu_wdata_code(cpu_wdata_code),
    .cpu_code(cpu_code), .cpu_len(cpu_len), .cpu_ts(cpu_ts), .cpu_id(cpu_id),
    .cpu_data(cpu_data), .cpu_timer(cpu_timer),
    .flag_clr(flag_clr), .irq_mask(irq_mask), .flags(flags), .irq(irq)
  );

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(input int mb, input logic [28:0] id, input logic [3:0] code);
    cpu_mb = 2'(mb); cpu_wr_id = 1'b1; cpu_wdata_id = id;
    cpu_wr_code = 1'b1; cpu_wdata_code = code;
    @(negedge clk);
    cpu_wr_id = 1'b0; cpu_wr_code = 1'b0;
  endtask

  task automatic rd_ctrl(input int mb);
    cpu_mb = 2'(mb); cpu_rd_ctrl = 1'b1;
    @(negedge clk);
    cpu_rd_ctrl = 1'b0;
  endtask

  task automatic rd_timer();
    cpu_rd_timer = 1'b1;
    @(negedge clk);
    cpu_rd_timer = 1'b0;
  endtask

  task automatic clr_flag(input int mb);
    flag_clr = 4'(1 << mb);
    @(negedge clk);
    flag_clr = '0;
    #1 chk_eq("R6 flag cleared by w1c", 64'(flags[mb]), 64'd0);
  endtask

  // present one frame with a staggered check of each update step
  task automatic send_traced(input int mb, input logic [28:0] id, input logic [63:0] data,
                             input logic [3:0] len, input logic [3:0] exp_code,
                             input bit clr_at_set);
    logic [28:0] old_id;
    logic [15:0] ts_exp;
    clr_flag(mb);
    cpu_mb = 2'(mb);
    #1 old_id = cpu_id;
    frm_valid = 1'b1; frm_mb = 2'(mb); frm_id = id; frm_data = data; frm_len = len;
    #1 chk_eq("R2 ready when idle", 64'(frm_ready), 64'd1);
    ts_exp = cpu_timer + 16'd1;
    @(negedge clk);
    frm_valid = 1'b0;
    #1 chk_eq("R7 busy in ts step", 64'(cpu_code[0]), 64'd1);
    chk_eq("R2 ready low while updating", 64'(frm_ready), 64'd0);
    chk_eq("R2 id untouched before body step", 64'(cpu_id), 64'(old_id));
    cpu_wr_code = 1'b1; cpu_wdata_code = 4'b0000;
    cpu_wr_id = 1'b1; cpu_wdata_id = ~id;
    @(negedge clk);
    cpu_wr_code = 1'b0; cpu_wr_id = 1'b0;
    #1 chk_eq("R3 timestamp", 64'(cpu_ts), 64'(ts_exp));
    chk_eq("R2 id untouched after ts step", 64'(cpu_id), 64'(old_id));
    @(negedge clk);
    #1 chk_eq("R2 id stored", 64'(cpu_id), 64'(id));
    chk_eq("R4 data stored", cpu_data, data);
    chk_eq("R4 length stored", 64'(cpu_len), 64'(len));
    chk_eq("R7 busy in body step", 64'(cpu_code[0]), 64'd1);
    @(negedge clk);
    if (clr_at_set) flag_clr = 4'(1 << mb);
    #1 chk_eq("R5 code value", 64'(cpu_code), 64'(exp_code));
    chk_eq("R2 flag not before code", 64'(flags[mb]), 64'd0);
    @(negedge clk);
    flag_clr = '0;
    #1 chk_eq("R6 flag set", 64'(flags[mb]), 64'd1);
    chk_eq("R11 busy writes ignored, id", 64'(cpu_id), 64'(id));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [28:0] keep_id;
    logic [28:0] a_id;
    logic [63:0] a_data;
    logic [15:0] t0;
    @(negedge clk);
    @(negedge clk);
    #1 chk_eq("R12 flags reset", 64'(flags), 64'd0);
    chk_eq("R12 irq reset", 64'(irq), 64'd0);
    chk_eq("R12 ready reset", 64'(frm_ready), 64'd1);
    chk_eq("R3 timer reset", 64'(cpu_timer), 64'd0);
    for (int m = 0; m < NMB; m++) begin
      cpu_mb = 2'(m);
      #1 chk_eq("R12 code reset", 64'(cpu_code), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    t0 = cpu_timer;
    for (int s = 1; s <= 4; s++) begin
      @(negedge clk);
      chk_eq("R3 timer step", 64'(cpu_timer), 64'(t0 + 16'(s)));
    end

    // sweep every mailbox and every length code
    for (int k = 0; k < 16; k++) begin
      if (k < NMB) arm(k % NMB, 29'h0, 4'b0100);
      else begin
        rd_ctrl(k % NMB);
        rd_timer();
      end
      send_traced(k % NMB, 29'(k * 32'h0135_79BD + 7),
                  {32'(k * 32'h0101_0101), 32'(~k)}, 4'(k), 4'b0010, k == 5);
    end

    // no service since last frame
    send_traced(0, 29'h1ABC_DEF0, 64'hDEAD_BEEF_0123_4567, 4'd8, 4'b0110, 1'b0);

    // irq over every mask and remaining-flag pattern
    for (int c = 0; c <= NMB; c++) begin
      logic [3:0] rem;
      rem = 4'(4'hF << c);
      if (c > 0) begin
        flag_clr = 4'(1 << (c - 1));
        @(negedge clk);
        flag_clr = '0;
      end
      #1 chk_eq("R6 flags after w1c", 64'(flags), 64'(rem));
      for (int m = 0; m < 16; m++) begin
        irq_mask = 4'(m);
        #1 chk_eq("R6 irq gating", 64'(irq), 64'(|(4'(m) & rem)));
      end
    end
    irq_mask = '0;

    // inactive mailbox drops frames
    arm(3, 29'h0555_0555, 4'b0000);
    cpu_mb = 2'd3;
    frm_valid = 1'b1; frm_mb = 2'd3; frm_id = 29'h0123; frm_data = '1; frm_len = 4'd2;
    #1 chk_eq("R1 inactive frame accepted", 64'(frm_ready), 64'd1);
    @(negedge clk);
    frm_valid = 1'b0;
    repeat (6) @(negedge clk);
    #1 chk_eq("R1 inactive id kept", 64'(cpu_id), 64'(29'h0555_0555));
    chk_eq("R1 inactive code kept", 64'(cpu_code), 64'd0);
    chk_eq("R1 inactive flag kept", 64'(flags[3]), 64'd0);

    // lock, hold, drop and release on mailbox 0
    cpu_mb = 2'd0;
    #1 keep_id = cpu_id;
    rd_ctrl(0);
    a_id = 29'h0AAA_0001; a_data = 64'h0A0A_0B0B_0C0C_0D0D;
    frm_valid = 1'b1; frm_mb = 2'd0; frm_id = a_id; frm_data = a_data; frm_len = 4'd5;
    #1 chk_eq("R9 held frame accepted", 64'(frm_ready), 64'd1);
    chk_eq("R10 no loss with free slot", 64'(rx_lost), 64'd0);
    @(negedge clk);
    frm_id = 29'h0BBB_0002; frm_data = 64'h1111_2222_3333_4444; frm_len = 4'd1;
    #1 chk_eq("R10 loss reported", 64'(rx_lost), 64'd1);
    @(negedge clk);
    frm_valid = 1'b0;
    repeat (5) @(negedge clk);
    #1 chk_eq("R8 locked id kept", 64'(cpu_id), 64'(keep_id));
    chk_eq("R8 locked flag kept", 64'(flags[0]), 64'd0);
    rd_timer();
    #1 chk_eq("R9 ready low while draining", 64'(frm_ready), 64'd0);
    repeat (5) @(negedge clk);
    #1 chk_eq("R9 held id written", 64'(cpu_id), 64'(a_id));
    chk_eq("R10 held data kept, dropped lost", cpu_data, a_data);
    chk_eq("R5 full after service", 64'(cpu_code), 64'(4'b0010));
    chk_eq("R9 flag after release", 64'(flags[0]), 64'd1);

    // lock moves from mailbox 1 to mailbox 2
    rd_ctrl(1);
    rd_ctrl(2);
    send_traced(1, 29'h0777_1234, 64'h5555_AAAA_5555_AAAA, 4'd3, 4'b0010, 1'b0);
    frm_valid = 1'b1; frm_mb = 2'd2; frm_id = 29'h02; frm_data = 64'h2; frm_len = 4'd2;
    @(negedge clk);
    frm_valid = 1'b0;
    repeat (5) @(negedge clk);
    #1 chk_eq("R8 moved lock holds mailbox 2", 64'(flags[2]), 64'd0);
    rd_timer();
    repeat (6) @(negedge clk);
    cpu_mb = 2'd2;
    #1 chk_eq("R8 mailbox 2 written after release", 64'(flags[2]), 64'd1);
    chk_eq("R8 mailbox 2 id", 64'(cpu_id), 64'h02);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule